// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block is a register-controlled master for the two-wire PHY management bus (MDC clock plus bidirectional MDIO data), running IEEE 802.3 clause-22 frames. Software sets a clock divider and a preamble switch in a control register. It then writes one 32-bit command word, and that word is the frame itself. The top nibble holds the start and opcode bits, followed by the PHY address, the register address, the turnaround pattern and the 16 data bits.

The block sends the optional preamble and then the command word, most significant bit first. For a read, it releases the data line and samples the 16 bits the PHY returns into the low half of the command register. When the last bit period ends, it sets a completion flag. Software clears that flag by writing 1 to it. A mask bit routes the flag onto a single interrupt line.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - every register reads 0;
  - mdc, mdio_oe and irq are 0;
  - mdio_o is 1.
- R2: The register word addresses are 0 for control, 1 for command, 2 for status and 3 for interrupt mask.
  - Control holds the divider in bits 6:0 and preamble enable in bit 7. It reads back as written.
  - The mask register holds its enable in bit 0.
- R3: While a frame runs, MDC spends (divider+1) system clocks in each half period and starts low. Between frames MDC stays low.
- R4: With preamble enabled, 32 one-bits precede the command word. With preamble disabled, the frame starts directly with bit 31 of the command word.
- R5: Command bits go out from bit 31 down to bit 0, one bit per MDC period. A new bit appears after each falling MDC edge.
- R6: A frame whose command bits 31:28 equal 0x6 is a read. In a read, mdio_oe is low from command bit 16 through bit 0. In every other frame, mdio_oe is high for the whole frame. Between frames mdio_oe is low.
- R7: In a read, MDIO is sampled on each rising MDC edge of bits 15..0. At completion, the sampled bits replace command bits 15:0, with bit 15 sampled first. A write frame leaves the command register unchanged.
- R8: The frame lasts exactly 2*(divider+1)*(32 or 64) clocks. Status bit 1 (busy) is high for that whole span. Status bit 0 (done) sets on the clock where busy clears.
- R9: Writing status with bit 0 set clears done. Writing status with bit 0 clear leaves done unchanged.
- R10: While busy, writes to the command register are ignored. Control writes made while busy take effect only from the next frame.
- R11: irq is high exactly when done and the mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register word address for reads |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO value seen on the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| irq | output | 1 | Masked completion interrupt |

## Verification
A wrong bit counter or preamble count shows on the port within one MDC half period. It appears as an MDIO bit that differs from the reference stream, or as busy dropping early or late against the exact frame length. A wrong divider or clock phase shows as an MDC level mismatch within (divider+1) clocks. Faults in read capture or in the release window stay hidden until completion, when the command word is read back or mdio_oe is compared at the second turnaround bit.

// File: rtl/mdio_pkg.sv
// Shared constants and register addresses for the management master.
package mdio_pkg;
    localparam int ADDR_W = 2;
    localparam int WORD_W = 32;
    localparam int DIV_W  = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_CMD  = 2'd1,
        A_STAT = 2'd2,
        A_MASK = 2'd3
    } reg_addr_e;

    localparam logic [3:0] OP_READ = 4'h6;
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: toggles mdc every (div+1) clocks while enabled and
// flags the clock on which a rising or falling MDC edge is produced.
// Assumes div is held stable for the whole enabled span.
module mdio_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = en && (cnt == div);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    // Half-period counter and MDC toggle; parked low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
// Frame engine: sends optional preamble and the command word MSB first,
// advancing on MDC falling edges and sampling read data on rising edges.
// Assumes start is only asserted while idle.
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int CMD_W   = 32,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              pre_in,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic [DIV_W-1:0]  div_q,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done_pulse,
    output logic              rdata_load,
    output logic [DATA_W-1:0] rdata
);
    localparam int PRE_W = $clog2(PRE_LEN + 1);
    localparam int POS_W = $clog2(CMD_W);
    localparam logic [POS_W-1:0] POS_TA2  = POS_W'(DATA_W);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(CMD_W - 1);

    logic [CMD_W-1:0] word_q;
    logic [PRE_W-1:0] pre_left;
    logic [POS_W-1:0] wpos;
    logic             is_read;
    logic             in_word;

    assign in_word    = (pre_left == '0);
    assign done_pulse = busy && fall && in_word && (wpos == '0);
    assign rdata_load = done_pulse && is_read;
    assign mdio_o     = (busy && in_word) ? word_q[CMD_W-1] : 1'b1;
    assign mdio_oe    = busy && !(is_read && in_word && (wpos <= POS_TA2));

    // Frame sequencing: load on start, step one bit per falling MDC edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            word_q   <= '0;
            pre_left <= '0;
            wpos     <= '0;
            is_read  <= 1'b0;
            div_q    <= '0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            word_q   <= cmd_in;
            pre_left <= pre_in ? PRE_W'(PRE_LEN) : '0;
            wpos     <= POS_LAST;
            is_read  <= (cmd_in[CMD_W-1 -: 4] == OP_READ);
            div_q    <= div_in;
        end else if (busy && fall) begin
            if (!in_word) begin
                pre_left <= pre_left - 1'b1;
            end else if (wpos == '0) begin
                busy <= 1'b0;
            end else begin
                wpos   <= wpos - 1'b1;
                word_q <= {word_q[CMD_W-2:0], 1'b0};
            end
        end
    end

    // Read capture: shift in MDIO on rising MDC edges of the data field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (busy && rise && is_read && in_word && (wpos < POS_TA2)) begin
            rdata <= {rdata[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Register file: control, command/data, status (done W1C, busy) and mask.
// Command writes are accepted only while idle; read data lands in bits
// 15:0 at read completion.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              busy,
    input  logic              done_pulse,
    input  logic              rdata_load,
    input  logic [DATA_W-1:0] rdata,
    output logic              start,
    output logic [WORD_W-1:0] cmd_q,
    output logic [DIV_W-1:0]  div,
    output logic              pre_en,
    output logic              done_flag,
    output logic              irq
);
    logic mask_q;

    assign start = wr_en && (wr_addr == A_CMD) && !busy;
    assign irq   = done_flag && mask_q;

    // Control and mask registers: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div    <= '0;
            pre_en <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                div    <= wr_data[DIV_W-1:0];
                pre_en <= wr_data[DIV_W];
            end
            if (wr_addr == A_MASK) begin
                mask_q <= wr_data[0];
            end
        end
    end

    // Command register: loaded by software when idle, low half by read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= wr_data;
        end else if (rdata_load) begin
            cmd_q[DATA_W-1:0] <= rdata;
        end
    end

    // Completion flag: set by the engine, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (done_pulse) begin
            done_flag <= 1'b1;
        end else if (wr_en && (wr_addr == A_STAT) && wr_data[0]) begin
            done_flag <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[DIV_W:0] = {pre_en, div};
            A_CMD:   rd_data = cmd_q;
            A_STAT:  rd_data[1:0] = {busy, done_flag};
            default: rd_data[0] = mask_q;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
// Top of the clause-22 management master: register file, MDC generator
// and frame engine. Pad tri-state is left to the instantiating level via
// mdio_o / mdio_oe / mdio_i.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              irq
);
    logic              busy;
    logic              start;
    logic              done_pulse;
    logic              rdata_load;
    logic              done_flag;
    logic              pre_en;
    logic              rise;
    logic              fall;
    logic [DIV_W-1:0]  div_reg;
    logic [DIV_W-1:0]  div_act;
    logic [DATA_W-1:0] rdata;
    logic [WORD_W-1:0] cmd_q;

    mdio_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done_pulse(done_pulse), .rdata_load(rdata_load),
        .rdata(rdata), .start(start), .cmd_q(cmd_q),
        .div(div_reg), .pre_en(pre_en), .done_flag(done_flag), .irq(irq)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(busy), .div(div_act),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_engine #(
        .DIV_W(DIV_W), .CMD_W(WORD_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(wr_data),
        .div_in(div_reg), .pre_in(pre_en), .rise(rise), .fall(fall),
        .mdio_i(mdio_i), .busy(busy), .div_q(div_act),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_pulse(done_pulse),
        .rdata_load(rdata_load), .rdata(rdata)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Property checker for mdio_master, attached by bind.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done_flag,
    input logic [31:0] cmd_q,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        irq
);
    // R3
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R6
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    // R8
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);
    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_q));
    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_flag(done_flag),
    .cmd_q(cmd_q), .mdc(mdc), .mdio_oe(mdio_oe), .irq(irq)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_i, mdio_o, mdio_oe, irq;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // Behavioural reference: a bit queue indexed by elapsed clocks.
    task automatic run_frame(input logic [31:0] cmd, input int dv, input bit pre,
                             input logic [15:0] phy, input bit inject);
        bit   q[$];
        int   half, total, pre_n, b, wp;
        bit   rd, exp_oe, exp_mdc;
        logic [31:0] v;
        pre_n = pre ? 32 : 0;
        for (int i = 0; i < pre_n; i++) q.push_back(1'b1);
        for (int i = 31; i >= 0; i--) q.push_back(cmd[i]);
        rd    = (cmd[31:28] == 4'h6);
        half  = dv + 1;
        total = 2 * half * q.size();
        reg_write(2'd0, {24'd0, pre, 7'(dv)});
        reg_write(2'd2, 32'd1);
        @(negedge clk);
        rd_addr = 2'd2;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = cmd;
        for (int t = 0; t <= total; t++) begin
            @(negedge clk);
            if (t == 0) wr_en = 1'b0;
            if (inject && t == 5) begin
                // R10: command write while busy must be dropped
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h5FFF_0000;
            end
            if (inject && t == 6) begin
                wr_addr = 2'd0; wr_data = 32'h0000_0000;
            end
            if (inject && t == 7) wr_en = 1'b0;
            if (t < total) begin
                b = t / (2 * half);
                wp = 31 - (b - pre_n);
                exp_mdc = ((t / half) % 2) == 1;
                exp_oe  = !(rd && b >= pre_n && wp <= 16);
                mdio_i  = (rd && b >= pre_n && wp <= 15) ? phy[wp] : 1'b1;
                // R3 / R8
                check(mdc == exp_mdc && rd_data[1], "R3/R8 mdc+busy",
                      {30'd0, rd_data[1], mdc}, {30'd0, 1'b1, exp_mdc});
                // R6
                check(mdio_oe == exp_oe, "R6 oe", {31'd0, mdio_oe}, {31'd0, exp_oe});
                // R4 / R5
                if (exp_oe)
                    check(mdio_o == q[b], "R4/R5 bit", {31'd0, mdio_o}, {31'd0, q[b]});
            end else begin
                // R8: end of frame exactly at total
                check(rd_data[1:0] == 2'b01 && !mdc && !mdio_oe, "R8 end",
                      {29'd0, mdc, rd_data[1:0]}, 32'h1);
            end
        end
        mdio_i = 1'b1;
        reg_read(2'd1, v);
        // R7 / R10
        check(v == (rd ? {cmd[31:16], phy} : cmd), "R7/R10 cmd readback",
              v, rd ? {cmd[31:16], phy} : cmd);
    endtask

    initial begin
        logic [31:0] v;
        mdio_i = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            check(v == 32'd0, "R1 reg reset", v, 32'd0);
        end
        check(!mdc && !mdio_oe && !irq && mdio_o, "R1 pins",
              {28'd0, mdc, mdio_oe, irq, mdio_o}, 32'h1);
        // R2 readback
        reg_write(2'd0, 32'h0000_009F);
        reg_read(2'd0, v);
        check(v == 32'h9F, "R2 ctrl", v, 32'h9F);
        reg_write(2'd3, 32'h1);
        reg_read(2'd3, v);
        check(v == 32'h1, "R2 mask", v, 32'h1);
        reg_write(2'd3, 32'h0);
        // write frame, preamble on
        run_frame({4'h5, 5'h03, 5'h11, 2'b10, 16'hBEEF}, 1, 1'b1, 16'h0, 1'b0);
        // R11 masked off
        check(irq == 1'b0, "R11 masked", {31'd0, irq}, 32'd0);
        reg_write(2'd3, 32'h1);
        #1 check(irq == 1'b1, "R11 unmasked", {31'd0, irq}, 32'd1);
        // R9 writing 0 keeps done
        reg_write(2'd2, 32'h0);
        reg_read(2'd2, v);
        check(v[0] == 1'b1, "R9 w0 no effect", v, 32'h1);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, v);
        check(v[0] == 1'b0 && !irq, "R9 w1 clears", v, 32'h0);
        reg_write(2'd3, 32'h0);
        // read frame, no preamble, fastest MDC
        run_frame({4'h6, 5'h1F, 5'h00, 2'b10, 16'h0000}, 0, 1'b0, 16'hA5C3, 1'b0);
        // read frame with writes while busy
        run_frame({4'h6, 5'h05, 5'h0A, 2'b10, 16'h7777}, 2, 1'b1, 16'h0F0F, 1'b1);
        reg_read(2'd0, v);
        // R10: control write while busy lands for later frames
        check(v == 32'h0, "R10 ctrl later", v, 32'h0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule